// File: doc/BRIEF.md
# Multi-Bus Interrupt Controller

This block collects interrupt requests from up to sixteen inter-core buses on behalf of one processor core. Each bus offers a data word with a valid/ready handshake. The controller keeps an enable bit and a handler address for every bus, together with one pending flag that the core uses to track interrupts it has not yet handled. When an enabled bus's request is taken in the normal, asynchronous way, the controller reports the handler address and the bus number on a vector output, and it sets the pending flag.

The core drives a bus selection mask and issues one of four commands:
- **enable**: the per-bus enables become a copy of the selection.
- **set-handler**: an address is written into the handler of every selected bus.
- **wait**: stalls until an interrupt has been taken.
- **receive**: takes one interrupt synchronously from any selected bus, with no handler involved.

A synchronous receive writes two words into an eight-entry output FIFO, the conveyor: the bus number first and then the data word. The core drains the conveyor through a valid/ready port.

Top module: `bus_irq_ctrl`

## Requirements
- R1: After reset, busy, pending, vector valid and conveyor valid are all 0, every enable is 0, and no ready is driven even when every bus requests.
- R2: The enable command (op 0) sets the enable of each bus whose selection bit is 1 and clears it for each bus whose selection bit is 0, all in the same cycle.
- R3: When the controller is not in a receive, an enabled bus with valid high sees ready high in that cycle. In the following cycle, vec_valid_o is 1 for one cycle with that bus's number and handler address, and pending is 1.
- R4: Ready is one-hot or zero. Among competing requests, the lowest-numbered bus wins.
- R5: A disabled bus sees ready low outside a receive, and it produces no vector.
- R6: The set-handler command (op 3) writes cmd_addr_i into the handler of each selected bus only. Unselected handlers keep their values.
- R7: The receive command (op 1) raises busy from the next cycle on. It ends when a selected bus is taken, whatever that bus's enable. That bus's number, zero-extended, is pushed into the conveyor, followed by its data word. No vector is produced and pending is unchanged. Busy is 0 in the cycle after the handshake.
- R8: While a receive is outstanding, buses outside the selection see ready low, even if they are enabled. Among the selected buses, the lowest-numbered one wins.
- R9: A receive takes no interrupt while the conveyor holds more than 6 words. It proceeds once at most 6 remain.
- R10: A wait command (op 2) issued while pending is 1 completes in the cycle it is accepted: busy stays 0 and pending becomes 0.
- R11: A wait command issued while pending is 0 keeps busy high until an interrupt is taken asynchronously, and the wait completes in that same cycle. This includes an interrupt taken in the cycle the command is accepted. After completion, pending is 0 and busy is 0.
- R12: The conveyor returns words in the order they were pushed and holds 8 words. cv_valid_o is 1 whenever it is not empty, and a word is removed when cv_valid_o and cv_ready_i are both 1.
- R13: While busy is 1, a command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_mask_i | input | NUM_BUS | Bus selection mask |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 enable, 1 receive, 2 wait, 3 set-handler |
| cmd_addr_i | input | ADDR_W | Handler address for set-handler |
| busy_o | output | 1 | Receive or wait outstanding |
| pending_o | output | 1 | Unhandled interrupt flag |
| irq_valid_i | input | NUM_BUS | Per-bus request |
| irq_data_i | input | NUM_BUS*DATA_W | Per-bus data word, bus b at bits b*DATA_W |
| irq_ready_o | output | NUM_BUS | Per-bus acceptance |
| vec_valid_o | output | 1 | Asynchronous take reported |
| vec_bus_o | output | log2(NUM_BUS) | Bus number taken |
| vec_addr_o | output | ADDR_W | Handler of that bus |
| cv_valid_o | output | 1 | Conveyor not empty |
| cv_data_o | output | DATA_W | Conveyor head word |
| cv_ready_i | input | 1 | Conveyor pop |

## Verification
The critical coincidence is a wait command that is accepted in the same cycle as an asynchronous interrupt arrives while pending is 0. A second coincidence, an enabled but unselected bus requesting during a receive, must be held off. The bench provokes the first case by raising an enabled bus's valid together with the wait strobe. It then judges the outcome at the ports: busy must stay low, pending must end at 0, and exactly one vector must appear. The second case is provoked by requesting on an enabled, unselected bus together with a selected one, and it is judged by which ready rises and by what lands in the conveyor.

// File: rtl/bus_irq_pkg.sv
package bus_irq_pkg;
  typedef enum logic [1:0] {
    CMD_ENABLE = 2'd0,
    CMD_RECV   = 2'd1,
    CMD_WAIT   = 2'd2,
    CMD_SETVEC = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/bus_irq_arb.sv
module bus_irq_arb #(
  parameter int N    = 16,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    gnt_o,
  output logic [ID_W-1:0] id_o,
  output logic            any_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign gnt_o[g]    = req_i[g] & ~taken[g];
    assign taken[g+1]  = taken[g] | req_i[g];
  end

  assign any_o = taken[N];

  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) id_o = id_o | ID_W'(i);
    end
  end
endmodule

// File: rtl/bus_irq_vec_tab.sv
module bus_irq_vec_tab #(
  parameter int N      = 16,
  parameter int ADDR_W = 16,
  parameter int ID_W   = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      wr_mask_i,
  input  logic              ien_we_i,
  input  logic              vec_we_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  input  logic [ID_W-1:0]   rd_id_i,
  output logic [N-1:0]      ien_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic              ien_q [N];
  logic [ADDR_W-1:0] hdl_q [N];

  for (genvar g = 0; g < N; g++) begin : g_bus
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ien_q[g] <= 1'b0;
        hdl_q[g] <= '0;
      end else begin
        if (ien_we_i) ien_q[g] <= wr_mask_i[g];
        if (vec_we_i && wr_mask_i[g]) hdl_q[g] <= vec_addr_i;
      end
    end
    assign ien_o[g] = ien_q[g];
  end

  assign rd_addr_o = hdl_q[rd_id_i];
endmodule

// File: rtl/bus_irq_conveyor.sv
// DEPTH must be a power of two, at least 2; caller pushes only with room for two words.
module bus_irq_conveyor #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push2_i,
  input  logic [W-1:0]     word0_i,
  input  logic [W-1:0]     word1_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok;

  assign pop_ok  = pop_i && (cnt_q != '0);
  assign wr_nxt  = wr_q + PTR_W'(1);
  assign valid_o = cnt_q != '0;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push2_i) begin
      mem_q[wr_q]   <= word0_i;
      mem_q[wr_nxt] <= word1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push2_i) wr_q <= wr_q + PTR_W'(2);
      if (pop_ok)  rd_q <= rd_q + PTR_W'(1);
      cnt_q <= cnt_q + (push2_i ? CNT_W'(2) : CNT_W'(0)) - (pop_ok ? CNT_W'(1) : CNT_W'(0));
    end
  end
endmodule

// File: rtl/bus_irq_ctrl.sv
module bus_irq_ctrl
  import bus_irq_pkg::*;
#(
  parameter int NUM_BUS    = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BUS-1:0]          sel_mask_i,
  input  logic                        cmd_valid_i,
  input  logic [1:0]                  cmd_op_i,
  input  logic [ADDR_W-1:0]           cmd_addr_i,
  output logic                        busy_o,
  output logic                        pending_o,
  input  logic [NUM_BUS-1:0]          irq_valid_i,
  input  logic [NUM_BUS*DATA_W-1:0]   irq_data_i,
  output logic [NUM_BUS-1:0]          irq_ready_o,
  output logic                        vec_valid_o,
  output logic [$clog2(NUM_BUS)-1:0]  vec_bus_o,
  output logic [ADDR_W-1:0]           vec_addr_o,
  output logic                        cv_valid_o,
  output logic [DATA_W-1:0]           cv_data_o,
  input  logic                        cv_ready_i
);
  localparam int ID_W  = $clog2(NUM_BUS);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  state_e            state_q, state_d;
  cmd_e              op;
  logic              cmd_fire, in_recv, room;
  logic              take_any, take_async, take_sync, wait_done;
  logic              pending_q, pending_d;
  logic [NUM_BUS-1:0] req, gnt, ien;
  logic [ID_W-1:0]   gnt_id;
  logic [ADDR_W-1:0] gnt_addr;
  logic [CNT_W-1:0]  cv_count;
  logic [DATA_W-1:0] gnt_data;

  assign op       = cmd_e'(cmd_op_i);
  assign cmd_fire = cmd_valid_i && (state_q == ST_IDLE);
  assign in_recv  = (state_q == ST_RECV);
  assign room     = cv_count <= CNT_W'(FIFO_DEPTH - 2);

  // receive: selection gates requests, enables ignored
  assign req = in_recv ? (irq_valid_i & sel_mask_i & {NUM_BUS{room}})
                       : (irq_valid_i & ien);

  bus_irq_arb #(.N(NUM_BUS), .ID_W(ID_W)) i_arb (
    .req_i (req),
    .gnt_o (gnt),
    .id_o  (gnt_id),
    .any_o (take_any)
  );

  assign irq_ready_o = gnt;
  assign take_async  = take_any && !in_recv;
  assign take_sync   = take_any && in_recv;
  assign gnt_data    = irq_data_i[gnt_id*DATA_W +: DATA_W];

  bus_irq_vec_tab #(.N(NUM_BUS), .ADDR_W(ADDR_W), .ID_W(ID_W)) i_tab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_mask_i  (sel_mask_i),
    .ien_we_i   (cmd_fire && op == CMD_ENABLE),
    .vec_we_i   (cmd_fire && op == CMD_SETVEC),
    .vec_addr_i (cmd_addr_i),
    .rd_id_i    (gnt_id),
    .ien_o      (ien),
    .rd_addr_o  (gnt_addr)
  );

  bus_irq_conveyor #(.DEPTH(FIFO_DEPTH), .W(DATA_W), .CNT_W(CNT_W)) i_cv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push2_i (take_sync),
    .word0_i (DATA_W'(gnt_id)),
    .word1_i (gnt_data),
    .pop_i   (cv_ready_i),
    .valid_o (cv_valid_o),
    .data_o  (cv_data_o),
    .count_o (cv_count)
  );

  // wait also completes on an interrupt taken in its accept cycle
  assign wait_done = ((state_q == ST_WAIT) && take_async) ||
                     (cmd_fire && op == CMD_WAIT && (pending_q || take_async));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_fire && op == CMD_RECV) state_d = ST_RECV;
        else if (cmd_fire && op == CMD_WAIT && !wait_done) state_d = ST_WAIT;
      end
      ST_RECV: if (take_sync)  state_d = ST_IDLE;
      ST_WAIT: if (take_async) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pending_d = pending_q;
    if (wait_done)       pending_d = 1'b0;
    else if (take_async) pending_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pending_q   <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_bus_o   <= '0;
      vec_addr_o  <= '0;
    end else begin
      state_q     <= state_d;
      pending_q   <= pending_d;
      vec_valid_o <= take_async;
      if (take_async) begin
        vec_bus_o  <= gnt_id;
        vec_addr_o <= gnt_addr;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign pending_o = pending_q;
endmodule

// File: rtl/bus_irq_ctrl_chk.sv
module bus_irq_ctrl_chk #(
  parameter int NUM_BUS    = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic [1:0]         cmd_op_i,
  input logic               busy_o,
  input logic               pending_o,
  input logic [NUM_BUS-1:0] sel_mask_i,
  input logic [NUM_BUS-1:0] irq_valid_i,
  input logic [NUM_BUS-1:0] irq_ready_o,
  input logic               vec_valid_o,
  input logic [NUM_BUS-1:0] ien_i,
  input logic [CNT_W-1:0]   cv_count_i,
  input logic               in_recv_i
);
  a_r4_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ready_o));

  a_r5_disabled_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_recv_i |-> (irq_ready_o & ~ien_i) == '0);

  a_r8_unsel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_recv_i |-> (irq_ready_o & ~sel_mask_i) == '0);

  a_r9_no_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_recv_i && int'(cv_count_i) > FIFO_DEPTH - 2) |-> irq_ready_o == '0);

  a_r3_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_recv_i && |(irq_ready_o & irq_valid_i)) |=> vec_valid_o);

  a_r7_sync_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_recv_i && |(irq_ready_o & irq_valid_i)) |=> (!vec_valid_o && !busy_o));

  a_r10_wait_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_op_i == 2'd2 && pending_o) |=> (!pending_o && !busy_o));

  a_r11_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !in_recv_i && (irq_ready_o & irq_valid_i) == '0) |=> busy_o);

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cv_count_i) <= FIFO_DEPTH);
endmodule

bind bus_irq_ctrl bus_irq_ctrl_chk #(
  .NUM_BUS(NUM_BUS), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .busy_o      (busy_o),
  .pending_o   (pending_o),
  .sel_mask_i  (sel_mask_i),
  .irq_valid_i (irq_valid_i),
  .irq_ready_o (irq_ready_o),
  .vec_valid_o (vec_valid_o),
  .ien_i       (ien),
  .cv_count_i  (cv_count),
  .in_recv_i   (in_recv)
);

// File: tb/test_bus_irq_ctrl.sv
module test_bus_irq_ctrl;
  localparam int NB = 16, DW = 32, AW = 16, DEPTH = 8;
  localparam logic [1:0] OP_EN = 2'd0, OP_RX = 2'd1, OP_WT = 2'd2, OP_SV = 2'd3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NB-1:0]     sel_mask_i = '0;
  logic              cmd_valid_i = 1'b0;
  logic [1:0]        cmd_op_i = '0;
  logic [AW-1:0]     cmd_addr_i = '0;
  logic              busy_o, pending_o;
  logic [NB-1:0]     irq_valid_i = '0;
  logic [NB*DW-1:0]  irq_data_i = '0;
  logic [NB-1:0]     irq_ready_o;
  logic              vec_valid_o;
  logic [3:0]        vec_bus_o;
  logic [AW-1:0]     vec_addr_o;
  logic              cv_valid_o;
  logic [DW-1:0]     cv_data_o;
  logic              cv_ready_i = 1'b0;

  bus_irq_ctrl #(.NUM_BUS(NB), .DATA_W(DW), .ADDR_W(AW), .FIFO_DEPTH(DEPTH)) i_bus_irq_ctrl (.*);

  always #5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  logic [AW-1:0] hdl_m [NB];
  logic [NB-1:0] ien_m = '0;
  logic          pend_m = 1'b0;
  logic [DW-1:0] fifo_m [$];

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  function automatic int lowest(input logic [NB-1:0] m);
    for (int i = 0; i < NB; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic cmd(input logic [1:0] op, input logic [NB-1:0] sel, input logic [AW-1:0] a);
    sel_mask_i = sel; cmd_op_i = op; cmd_addr_i = a; cmd_valid_i = 1'b1;
    if (op == OP_EN) ien_m = sel;
    if (op == OP_SV) for (int b = 0; b < NB; b++) if (sel[b]) hdl_m[b] = a;
    step();
    cmd_valid_i = 1'b0;
  endtask

  task automatic load_data();
    for (int b = 0; b < NB; b++) irq_data_i[b*DW +: DW] = $urandom;
  endtask

  task automatic async_take(input logic [NB-1:0] m);
    int w;
    load_data();
    irq_valid_i = m;
    #1;
    w = lowest(m & ien_m);
    chk("R4 grant", irq_ready_o, (w >= 0) ? (NB'(1) << w) : 0);
    step();
    irq_valid_i = '0;
    if (w >= 0) begin
      chk("R3 vec_valid", vec_valid_o, 1);
      chk("R3 vec_bus", vec_bus_o, w);
      chk("R6 vec_addr", vec_addr_o, hdl_m[w]);
      chk("R3 pending", pending_o, 1);
      pend_m = 1'b1;
    end else begin
      chk("R5 no vector", vec_valid_o, 0);
    end
  endtask

  task automatic recv_once(input int b);
    cmd(OP_RX, NB'(1) << b, '0);
    chk("R7 busy", busy_o, 1);
    load_data();
    irq_valid_i = NB'(1) << b;
    #1;
    chk("R7 ready", irq_ready_o, NB'(1) << b);
    fifo_m.push_back(DW'(b));
    fifo_m.push_back(irq_data_i[b*DW +: DW]);
    step();
    irq_valid_i = '0;
    chk("R7 done", busy_o, 0);
  endtask

  task automatic pop_one();
    logic [DW-1:0] e;
    e = fifo_m.pop_front();
    chk("R12 valid", cv_valid_o, 1);
    chk("R12 order", cv_data_o, e);
    cv_ready_i = 1'b1;
    step();
    cv_ready_i = 1'b0;
  endtask

  task automatic drain();
    while (fifo_m.size() > 0) pop_one();
    chk("R12 empty", cv_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < NB; b++) hdl_m[b] = '0;
    irq_valid_i = '1;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 ready", irq_ready_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 pending", pending_o, 0);
    chk("R1 vec", vec_valid_o, 0);
    chk("R1 cv", cv_valid_o, 0);
    rst_ni = 1'b1;
    step();
    chk("R1 ready after release", irq_ready_o, 0);
    irq_valid_i = '0;

    // per-bus handlers, then a group overwrite (R6)
    for (int b = 0; b < NB; b++) cmd(OP_SV, NB'(1) << b, AW'($urandom));
    cmd(OP_SV, 16'h0a50, 16'hbeef);

    // R2: enable follows selection
    cmd(OP_EN, 16'h00ff, '0);
    cmd(OP_EN, 16'h0f0f, '0);
    async_take(16'h0010);
    async_take(16'h0110);
    cmd(OP_WT, '0, '0);
    chk("R10 busy", busy_o, 0);
    chk("R10 pending", pending_o, 0);
    pend_m = 1'b0;

    // random mix
    for (int it = 0; it < 300; it++) begin
      int r;
      r = $urandom % 4;
      if (r == 0) cmd(OP_EN, NB'($urandom), '0);
      if (r == 1) cmd(OP_SV, NB'($urandom), AW'($urandom));
      async_take(NB'($urandom & $urandom));
      if (pend_m && (it % 2 == 0)) begin
        cmd(OP_WT, '0, '0);
        chk("R10 busy", busy_o, 0);
        chk("R10 pending", pending_o, 0);
        pend_m = 1'b0;
      end
    end
    if (pend_m) begin cmd(OP_WT, '0, '0); pend_m = 1'b0; end
    chk("R10 cleared", pending_o, 0);

    // R11: blocking wait, R13: command ignored while busy
    cmd(OP_EN, 16'h0001, '0);
    cmd(OP_WT, '0, '0);
    chk("R11 busy", busy_o, 1);
    repeat (3) step();
    chk("R11 still busy", busy_o, 1);
    sel_mask_i = 16'h0002; cmd_op_i = OP_EN; cmd_valid_i = 1'b1;
    step();
    cmd_valid_i = 1'b0;
    irq_valid_i = 16'h0001;
    #1;
    chk("R11 ready", irq_ready_o, 1);
    step();
    irq_valid_i = '0;
    chk("R11 done busy", busy_o, 0);
    chk("R11 done pending", pending_o, 0);
    chk("R11 vector", vec_valid_o, 1);
    irq_valid_i = 16'h0002;
    #1;
    chk("R13 enable ignored", irq_ready_o, 0);
    irq_valid_i = '0;

    // R11 collision: wait accepted with interrupt in the same cycle
    irq_valid_i = 16'h0001;
    cmd(OP_WT, '0, '0);
    irq_valid_i = '0;
    chk("R11 collision busy", busy_o, 0);
    chk("R11 collision pending", pending_o, 0);
    chk("R11 collision vector", vec_valid_o, 1);
    step();
    chk("R11 single vector", vec_valid_o, 0);

    // R7/R8: receive ignores enables, holds unselected
    cmd(OP_RX, 16'h0030, '0);
    chk("R7 busy", busy_o, 1);
    irq_valid_i = 16'h0001;
    #1;
    chk("R8 enabled unselected held", irq_ready_o, 0);
    step();
    chk("R8 still busy", busy_o, 1);
    load_data();
    irq_valid_i = 16'h0031;
    #1;
    chk("R8 lowest selected", irq_ready_o, 16'h0010);
    fifo_m.push_back(DW'(4));
    fifo_m.push_back(irq_data_i[4*DW +: DW]);
    step();
    irq_valid_i = '0;
    chk("R7 done", busy_o, 0);
    chk("R7 no vector", vec_valid_o, 0);
    chk("R7 pending", pending_o, 0);
    drain();

    // R9: room for two words
    for (int k = 0; k < 4; k++) recv_once(12 + k);
    cmd(OP_RX, 16'h8000, '0);
    irq_valid_i = 16'h8000;
    #1;
    chk("R9 full", irq_ready_o, 0);
    step();
    chk("R9 stalled", busy_o, 1);
    pop_one();
    chk("R9 seven", irq_ready_o, 0);
    pop_one();
    chk("R9 six", irq_ready_o, 16'h8000);
    fifo_m.push_back(DW'(15));
    fifo_m.push_back(irq_data_i[15*DW +: DW]);
    step();
    irq_valid_i = '0;
    chk("R9 done", busy_o, 0);
    chk("R12 size", fifo_m.size(), 8);
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule